// File: doc/BRIEF.md
# Slew-Limited Digital Phase-Locked Loop

This block locks a numerically controlled oscillator to a reference strobe that arrives once per reference period. A phase accumulator runs from the master clock. Its step is a nominal tuning word plus a correction. The tuning word belongs to one of four output rates, picked by a 2-bit select. On every reference strobe the block measures how far the strobe sits from the oscillator's most recent carry. It takes the shorter way round the period. It scales that distance, saturates it so the output phase cannot slew by more than 5 ns in any 125 us, and passes it through a single-pole low-pass filter. The filtered value becomes the frequency correction.

Two external flags choose the mode. One is a freerun demand from the reference state logic and the other is a reference-impairment flag. When neither is raised the loop runs in Normal mode and tracks the reference. When either is raised the loop goes to Freerun. In Freerun the correction is held at zero, the filter is emptied and reference strobes are ignored, so the output frequency is exactly the nominal word on the master clock. The carry pulse, the accumulator MSB (a square-wave output clock), the mode and the applied correction are all available at the ports.

Top module: `slew_dpll`

## Requirements
- R1: While reset is low and in the first cycle after it, ncoCarry, outClk and lockOut are 0 and tuneOffset is 0.
- R2: lockOut is registered: after each rising clock edge it equals NOT(forceFree OR refBad) as sampled at that edge. lockOut = 1 means Normal mode and 0 means Freerun.
- R3: At every edge the ACC_W-bit accumulator adds word[fbSel] + tuneOffset, modulo 2^ACC_W. word = floor(rate * 2^ACC_W / CLK_HZ). The fbSel codes are 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz and 3 = 19.44 MHz. ncoCarry is 1 for the one cycle after an edge at which the sum wrapped, and outClk is the accumulator MSB. From reset with fbSel = 0, the first carry follows the 2501st edge.
- R4: Let s be the number of edges since the last carry (s = 0 while ncoCarry is 1). Let P = floor(CLK_HZ / rate) and H = floor(P/2). A refPulse sampled in Normal mode yields the error -s when s <= H and P - s otherwise.
- R5: The error is multiplied by 2^GAIN_SH and then saturated to plus or minus L = floor(word[fbSel] / 25000), the per-cycle step that moves the phase by 5 ns per 125 us.
- R6: The limited error is captured at the edge where refPulse is sampled. At the next edge the filter updates y = y + floor((err - y) / 2^FILT_SH). tuneOffset shows y after that second edge and changes at no other time while the mode and fbSel are held.
- R7: In Freerun, tuneOffset is 0, refPulse has no effect, and the accumulator steps by exactly word[fbSel].
- R8: On entering Normal mode the filter starts from zero, so tuneOffset is 0 in the first Normal cycle.
- R9: A change of fbSel clears the filter and drops any error that is pending, so tuneOffset is 0 after the first edge that sees the new code.
- R10: Whenever fbSel has been stable over the last edge, |tuneOffset| <= L for the current fbSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominally 20 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | One-cycle strobe marking the reference edge |
| forceFree | input | 1 | State logic demands Freerun |
| refBad | input | 1 | Reference is impaired; forces Freerun |
| fbSel | input | 2 | Feedback / output rate select (R3 codes) |
| ncoCarry | output | 1 | Oscillator wrap pulse (feedback edge) |
| outClk | output | 1 | Accumulator MSB, square output clock |
| lockOut | output | 1 | 1 = Normal (tracking), 0 = Freerun |
| tuneOffset | output | ACC_W (32) | Signed correction added to the tuning word |

## Verification
The bench places single strobes 100 cycles after a carry and 100 cycles before the next one. A detector that picks the wrong side of the half period, or inverts the sign, then steers the wrong way and shows -5 and +4 swapped. The same strobes use an error far above the saturation bound. A missing or misplaced limiter therefore gives a first filter step much larger than L/16, and a logical rather than arithmetic shift in the filter leaves the wrong value after rounding. Mode exits and rate changes come after a nonzero correction has built up, so a filter that is not cleared leaks the old correction into Freerun or into the new rate. The first carry after reset is counted to pin down the tuning word and the carry latency.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  localparam int NUM_RATES = 4;
  localparam int SEL_W     = $clog2(NUM_RATES);

  // Feedback rates in Hz, indexed by the select code.
  localparam int unsigned RATE_HZ [NUM_RATES] = '{8000, 1544000, 2048000, 19440000};

  // Control-to-datapath strobes.
  typedef struct packed {
    logic sample;  // capture limited phase error this edge
    logic update;  // advance loop filter this edge
    logic clear;   // empty loop filter and pending error
    logic apply;   // feed the filter output to the oscillator
  } dpllStrobe_t;

  // Nominal phase increment for a rate on a given master clock.
  function automatic longint unsigned tuneWord(input longint unsigned rateHz,
                                               input longint unsigned clkHz,
                                               input int accW);
    return (rateHz << accW) / clkHz;
  endfunction

  // Per-cycle correction bound holding the slope to 5 ns per 125 us.
  function automatic longint unsigned slewLimit(input longint unsigned word,
                                                input longint unsigned slewDiv);
    return word / slewDiv;
  endfunction

endpackage

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
  import dpll_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refPulse,
  input  logic             forceFree,
  input  logic             refBad,
  input  logic [SEL_W-1:0] fbSel,
  output dpllStrobe_t      strobe,
  output logic             lockOut
);

  logic             modeNormal;
  logic             pendErr;
  logic [SEL_W-1:0] selPrev;
  logic             selMove;
  logic             wantNormal;

  assign wantNormal = ~(forceFree | refBad);
  assign selMove    = (fbSel != selPrev);

  always_comb begin
    strobe.clear  = ~modeNormal | selMove;
    strobe.sample = modeNormal & refPulse & ~selMove;
    strobe.update = pendErr & ~strobe.clear;
    strobe.apply  = modeNormal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeNormal <= 1'b0;
      pendErr    <= 1'b0;
      selPrev    <= '0;
    end else begin
      modeNormal <= wantNormal;
      pendErr    <= strobe.sample;
      selPrev    <= fbSel;
    end
  end

  assign lockOut = modeNormal;

endmodule

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int CLK_HZ   = 20000000,
  parameter int ACC_W    = 32,
  parameter int CNT_W    = 16,
  parameter int GAIN_SH  = 4,
  parameter int FILT_SH  = 4,
  parameter int SLEW_DIV = 25000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpllStrobe_t             strobe,
  input  logic [SEL_W-1:0]        fbSel,
  output logic                    ncoCarry,
  output logic                    outClk,
  output logic signed [ACC_W-1:0] tuneOffset
);

  localparam int PE_W   = CNT_W + 2;
  localparam int SC_W   = PE_W + GAIN_SH;
  localparam int CMP_W  = ((SC_W > ACC_W) ? SC_W : ACC_W) + 1;
  localparam int DIFF_W = ACC_W + 1;

  // Per-rate constant tables.
  logic [ACC_W-1:0]        wordTab   [NUM_RATES];
  logic [CNT_W-1:0]        periodTab [NUM_RATES];
  logic signed [ACC_W-1:0] limitTab  [NUM_RATES];

  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_rate
    localparam longint unsigned WORD_C =
      tuneWord(64'(RATE_HZ[gi]), 64'(CLK_HZ), ACC_W);
    assign wordTab[gi]   = ACC_W'(WORD_C);
    assign periodTab[gi] = CNT_W'(CLK_HZ / RATE_HZ[gi]);
    assign limitTab[gi]  = ACC_W'(slewLimit(WORD_C, 64'(SLEW_DIV)));
  end

  // Oscillator.
  logic [ACC_W-1:0]        acc;
  logic [ACC_W:0]          accSum;
  logic [ACC_W-1:0]        incr;
  logic signed [ACC_W-1:0] filtY;
  logic signed [ACC_W-1:0] appliedCorr;
  logic [CNT_W-1:0]        sinceFb;

  assign appliedCorr = strobe.apply ? filtY : '0;
  assign incr        = wordTab[fbSel] + $unsigned(appliedCorr);
  assign accSum      = {1'b0, acc} + {1'b0, incr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      ncoCarry <= 1'b0;
      sinceFb  <= '0;
    end else begin
      acc      <= accSum[ACC_W-1:0];
      ncoCarry <= accSum[ACC_W];
      if (accSum[ACC_W])      sinceFb <= '0;
      else if (!(&sinceFb))   sinceFb <= sinceFb + 1'b1;
    end
  end

  assign outClk = acc[ACC_W-1];

  // Phase detector: signed distance to the nearer feedback edge.
  logic signed [PE_W-1:0] sExt;
  logic signed [PE_W-1:0] perExt;
  logic signed [PE_W-1:0] halfExt;
  logic signed [PE_W-1:0] phErr;

  assign sExt    = $signed({2'b00, sinceFb});
  assign perExt  = $signed({2'b00, periodTab[fbSel]});
  assign halfExt = perExt >>> 1;
  assign phErr   = (sExt <= halfExt) ? -sExt : (perExt - sExt);

  // Slope limiter: scale and saturate to the 5 ns per frame bound.
  logic signed [CMP_W-1:0] scaledErr;
  logic signed [CMP_W-1:0] limExt;
  logic signed [CMP_W-1:0] limErr;

  assign scaledErr = CMP_W'(phErr) <<< GAIN_SH;
  assign limExt    = CMP_W'(limitTab[fbSel]);

  always_comb begin
    if (scaledErr > limExt)       limErr = limExt;
    else if (scaledErr < -limExt) limErr = -limExt;
    else                          limErr = scaledErr;
  end

  // Single-pole loop filter.
  logic signed [ACC_W-1:0]  errReg;
  logic signed [DIFF_W-1:0] filtDiff;
  logic signed [DIFF_W-1:0] filtStep;

  assign filtDiff = DIFF_W'(errReg) - DIFF_W'(filtY);
  assign filtStep = filtDiff >>> FILT_SH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg <= '0;
      filtY  <= '0;
    end else begin
      if (strobe.sample) errReg <= ACC_W'(limErr);
      if (strobe.clear)       filtY <= '0;
      else if (strobe.update) filtY <= filtY + ACC_W'(filtStep);
    end
  end

  assign tuneOffset = appliedCorr;

endmodule

// File: rtl/slew_dpll.sv
module slew_dpll
  import dpll_pkg::*;
#(
  parameter int CLK_HZ   = 20000000,
  parameter int ACC_W    = 32,
  parameter int CNT_W    = 16,
  parameter int GAIN_SH  = 4,
  parameter int FILT_SH  = 4,
  parameter int SLEW_DIV = 25000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refPulse,
  input  logic                    forceFree,
  input  logic                    refBad,
  input  logic [1:0]              fbSel,
  output logic                    ncoCarry,
  output logic                    outClk,
  output logic                    lockOut,
  output logic signed [ACC_W-1:0] tuneOffset
);

  dpllStrobe_t strobe;

  dpll_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refPulse  (refPulse),
    .forceFree (forceFree),
    .refBad    (refBad),
    .fbSel     (fbSel),
    .strobe    (strobe),
    .lockOut   (lockOut)
  );

  dpll_datapath #(
    .CLK_HZ   (CLK_HZ),
    .ACC_W    (ACC_W),
    .CNT_W    (CNT_W),
    .GAIN_SH  (GAIN_SH),
    .FILT_SH  (FILT_SH),
    .SLEW_DIV (SLEW_DIV)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fbSel      (fbSel),
    .ncoCarry   (ncoCarry),
    .outClk     (outClk),
    .tuneOffset (tuneOffset)
  );

endmodule

// File: rtl/slew_dpll_checker.sv
module slew_dpll_checker
  import dpll_pkg::*;
#(
  parameter int CLK_HZ   = 20000000,
  parameter int ACC_W    = 32,
  parameter int SLEW_DIV = 25000
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    refPulse,
  input logic                    forceFree,
  input logic                    refBad,
  input logic [1:0]              fbSel,
  input logic                    lockOut,
  input logic signed [ACC_W-1:0] tuneOffset
);

  logic signed [ACC_W-1:0] boundTab [NUM_RATES];
  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_bound
    assign boundTab[gi] = ACC_W'(slewLimit(tuneWord(64'(RATE_HZ[gi]), 64'(CLK_HZ), ACC_W),
                                           64'(SLEW_DIV)));
  end

  logic signed [ACC_W-1:0] bound;
  assign bound = boundTab[fbSel];

  AST_LOCK_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    !(forceFree || refBad) |=> lockOut); // R2

  AST_LOCK_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    (forceFree || refBad) |=> !lockOut); // R2

  AST_REENTRY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> (tuneOffset == '0)); // R8

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (fbSel == $past(fbSel)) |-> ((tuneOffset <= bound) && (tuneOffset >= -bound))); // R10

  AST_STEP_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    ((tuneOffset != $past(tuneOffset)) && lockOut && $past(lockOut)
      && (fbSel == $past(fbSel)) && ($past(fbSel) == $past(fbSel, 2)))
      |-> $past(refPulse, 2)); // R6

endmodule

bind slew_dpll slew_dpll_checker #(
  .CLK_HZ   (CLK_HZ),
  .ACC_W    (ACC_W),
  .SLEW_DIV (SLEW_DIV)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refPulse   (refPulse),
  .forceFree  (forceFree),
  .refBad     (refBad),
  .fbSel      (fbSel),
  .lockOut    (lockOut),
  .tuneOffset (tuneOffset)
);

// File: tb/tb_slew_dpll.sv
`timescale 1ns/1ps
module tb_slew_dpll;

  localparam int     ACC_W = 32;
  localparam longint MOD   = 64'd1 << ACC_W;
  localparam longint CLKHZ = 20000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genPulse = 1'b0;
  logic manPulse = 1'b0;
  logic refPulse;
  logic forceFree = 1'b1;
  logic refBad = 1'b0;
  logic [1:0] fbSel = 2'd0;
  logic ncoCarry, outClk, lockOut;
  logic signed [ACC_W-1:0] tuneOffset;

  assign refPulse = genPulse | manPulse;

  always #5 clk = ~clk;

  slew_dpll dut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .forceFree(forceFree),
    .refBad(refBad), .fbSel(fbSel), .ncoCarry(ncoCarry), .outClk(outClk),
    .lockOut(lockOut), .tuneOffset(tuneOffset)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Rate constants derived from the requirement formulas (R3, R4, R5).
  function automatic longint rateOf(input int sel);
    case (sel)
      0: return 8000;
      1: return 1544000;
      2: return 2048000;
      default: return 19440000;
    endcase
  endfunction
  function automatic longint wordOf(input int sel);
    return (rateOf(sel) * MOD) / CLKHZ;
  endfunction
  function automatic longint periodOf(input int sel);
    return CLKHZ / rateOf(sel);
  endfunction
  function automatic longint limitOf(input int sel);
    return wordOf(sel) / 25000;
  endfunction

  // Scoreboard: reference model pushes expected outputs, monitor pops them.
  typedef struct {
    bit     carry;
    bit     clkBit;
    bit     lock;
    longint offset;
  } expItem_t;
  expItem_t expQ[$];

  longint mAcc, mSince, mY, mErr;
  bit     mNormal, mPend;
  int     mSel;

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = 0; mSince = 0; mY = 0; mErr = 0; mNormal = 0; mPend = 0; mSel = 0;
    end else begin
      bit selMove, clr, smp, upd, cy;
      longint corr, sum, s, p, e, x, lim, nY;
      expItem_t it;
      selMove = (int'(fbSel) != mSel);
      clr = !mNormal || selMove;
      smp = mNormal && refPulse && !selMove;
      upd = mPend && !clr;
      corr = mNormal ? mY : 0;
      sum = mAcc + ((wordOf(fbSel) + corr) % MOD);
      cy = (sum >= MOD);
      s = mSince; p = periodOf(fbSel);
      e = (s <= p / 2) ? -s : (p - s);
      x = e * 16;
      lim = limitOf(fbSel);
      if (x > lim) x = lim;
      if (x < -lim) x = -lim;
      nY = clr ? 0 : (upd ? mY + ((mErr - mY) >>> 4) : mY);
      if (smp) mErr = x;
      mY = nY;
      mAcc = sum % MOD;
      mSince = cy ? 0 : ((s < 65535) ? s + 1 : s);
      mPend = smp;
      mNormal = !(forceFree || refBad);
      mSel = int'(fbSel);
      it.carry = cy; it.clkBit = mAcc[31]; it.lock = mNormal;
      it.offset = mNormal ? mY : 0;
      expQ.push_back(it);
    end
  end

  always @(negedge clk) begin
    if (!finished && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(ncoCarry == it.carry, "R3 carry", longint'(ncoCarry), longint'(it.carry));
      check(outClk == it.clkBit, "R3 outClk", longint'(outClk), longint'(it.clkBit));
      check(lockOut == it.lock, "R2 lock", longint'(lockOut), longint'(it.lock));
      check(longint'(tuneOffset) == it.offset, "R6 offset", longint'(tuneOffset), it.offset);
    end
  end

  // Background reference generator.
  bit genOn = 0;
  int genPer = 2500;
  always @(negedge clk) begin
    static int cnt = 0;
    genPulse <= 1'b0;
    if (genOn) begin
      cnt = cnt + 1;
      if (cnt >= genPer) begin
        cnt = 0;
        genPulse <= 1'b1;
      end
    end
  end

  task automatic waitCarry();
    do @(negedge clk); while (!ncoCarry);
  endtask

  task automatic finish();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish();
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ncoCarry == 0, "R1 carry", longint'(ncoCarry), 0);
    check(outClk == 0, "R1 outClk", longint'(outClk), 0);
    check(lockOut == 0, "R1 lock", longint'(lockOut), 0);
    check(tuneOffset == 0, "R1 offset", longint'(tuneOffset), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ncoCarry == 0 && lockOut == 0 && tuneOffset == 0, "R1 first cycle", 0, 0);

    // R3: first carry from reset, 8 kHz word, follows edge 2501
    n = 1;
    while (!ncoCarry && n < 3000) begin @(negedge clk); n++; end
    check(n == 2501, "R3 first carry", n, 2501);

    // R7: freerun ignores references
    genOn = 1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      check(tuneOffset == 0, "R7 freerun offset", longint'(tuneOffset), 0);
    end
    genOn = 0;
    repeat (3) @(negedge clk);

    // R2/R8: enter Normal, correction starts at zero
    forceFree = 1'b0;
    @(negedge clk);
    check(lockOut == 1, "R2 enter normal", longint'(lockOut), 1);
    check(tuneOffset == 0, "R8 zero on entry", longint'(tuneOffset), 0);

    // R4/R5/R6: feedback leads by 100 cycles -> clamp -68 -> first step -5
    waitCarry();
    repeat (100) @(negedge clk);
    manPulse = 1'b1;
    @(negedge clk);
    manPulse = 1'b0;
    check(tuneOffset == 0, "R6 latency", longint'(tuneOffset), 0);
    @(negedge clk);
    check(tuneOffset == -5, "R5 lead step", longint'(tuneOffset), -5);

    // R2 via refBad, R8 filter cleared on re-entry
    refBad = 1'b1;
    @(negedge clk);
    check(lockOut == 0, "R2 impaired", longint'(lockOut), 0);
    check(tuneOffset == 0, "R7 freerun offset", longint'(tuneOffset), 0);
    refBad = 1'b0;
    @(negedge clk);
    check(lockOut == 1 && tuneOffset == 0, "R8 re-entry", longint'(tuneOffset), 0);

    // R4: reference 100 cycles before next carry -> +68 -> step +4
    waitCarry();
    repeat (2400) @(negedge clk);
    manPulse = 1'b1;
    @(negedge clk);
    manPulse = 1'b0;
    @(negedge clk);
    check(tuneOffset == 4, "R4 lag step", longint'(tuneOffset), 4);

    // Closed-loop tracking with periodic references
    genPer = 2497;
    genOn = 1;
    for (int f = 0; f < 20; f++) begin
      repeat (2500) @(negedge clk);
      check(tuneOffset <= 68 && tuneOffset >= -68, "R10 bound", longint'(tuneOffset), 68);
    end

    // R9: rate change clears the filter
    fbSel = 2'd2;
    @(negedge clk);
    check(tuneOffset == 0, "R9 select clear", longint'(tuneOffset), 0);
    genPer = 9;
    repeat (3000) @(negedge clk);
    check(tuneOffset <= limitOf(2) && tuneOffset >= -limitOf(2), "R10 bound 2M",
          longint'(tuneOffset), limitOf(2));
    fbSel = 2'd3;
    genPer = 3;
    repeat (500) @(negedge clk);
    fbSel = 2'd1;
    genPer = 13;
    @(negedge clk);
    check(tuneOffset == 0, "R9 select clear", longint'(tuneOffset), 0);
    repeat (2000) @(negedge clk);

    // R7: freerun with references still arriving
    forceFree = 1'b1;
    @(negedge clk);
    check(lockOut == 0, "R2 leave normal", longint'(lockOut), 0);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      check(tuneOffset == 0, "R7 refs ignored", longint'(tuneOffset), 0);
    end
    genOn = 0;
    repeat (4) @(negedge clk);
    finish();
  end

endmodule